// File: doc/BRIEF.md
# Sub-word Field Extract, Insert and Rotate Unit

This block is a purely combinational slice of a 32-bit execution datapath. It handles operations on nibble (4-bit), byte (8-bit) and halfword (16-bit) fields. An instruction that would otherwise need a shift, a mask and an OR is done with a single result word. That result is written back to the destination register.

There are three families of operation. The extract family takes an indexed field out of the source operand and returns it right-justified with zeros above it. The insert family replaces one indexed field of the current destination value with the low field of the source, and keeps every other bit. The rotate-insert family shifts the destination left by one field width and drops the low field of the source into the bits that were freed.

The only output is the result word plus a flag for unsupported opcodes. The source operand is only read, so no operation has a side effect on it. Opcode decode and the register file sit outside the block.

Top module: `subword_unit`

## Requirements
- R1: Opcode 0 (extract nibble) returns bits [4k+3:4k] of `src_val` in result bits [3:0], with k = `fld_idx` (0 to 7).
- R2: Opcode 1 (extract byte) returns bits [8k+7:8k] of `src_val` with k = `fld_idx[1:0]`. Opcode 2 (extract halfword) returns bits [16k+15:16k] with k = `fld_idx[0]`. In both cases the field lands in the low bits of the result.
- R3: For opcodes 0, 1 and 2, every result bit above the field width is zero.
- R4: Opcodes 3, 4 and 5 (insert nibble, byte, halfword) return `dst_val` with field k replaced by the low 4, 8 or 16 bits of `src_val`. All other bits of `dst_val` are unchanged. k is chosen as in R1 and R2.
- R5: Opcodes 6, 7 and 8 (rotate-insert nibble, byte, halfword) return `dst_val` shifted left by 4, 8 or 16. The vacated low bits hold the low 4, 8 or 16 bits of `src_val`.
- R6: For byte operations, index bit 2 has no effect on the result. For halfword operations, index bits 2 and 1 have no effect.
- R7: Opcodes 9 to 15 return `dst_val` unchanged and drive `bad_op` high. Opcodes 0 to 8 drive `bad_op` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, 0 to 8 legal |
| fld_idx | input | 3 | Field index; low bits used per width |
| dst_val | input | 32 | Current destination value |
| src_val | input | 32 | Source operand |
| res_val | output | 32 | Word written back to destination |
| bad_op | output | 1 | High for an unsupported opcode |

## Verification
The hardest case to reach is the aliasing of the index at the narrower widths. A design that decodes one index bit too many for bytes or halfwords would select an out-of-range field, or wrap to a wrong field. That error only shows when the unused high index bits are nonzero. The stimulus therefore sweeps all eight index values for every opcode, including the byte and halfword ones, and uses several operand patterns on each. The patterns include all-ones and alternating bits, so a field placed one slot off, or a leaked upper bit, changes the result.

// File: rtl/subword_unit.sv
module subword_unit #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      op_sel,
  input  logic [2:0]      fld_idx,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] res_val,
  output logic            bad_op
);
  localparam int NWID = 3;

  logic [XLEN-1:0] get_r [NWID];
  logic [XLEN-1:0] set_r [NWID];
  logic [XLEN-1:0] rol_r [NWID];

  for (genvar g = 0; g < NWID; g++) begin : g_wid
    localparam int FW = 4 << g;
    localparam int IW = 3 - g;
    localparam logic [XLEN-1:0] LOMASK = (XLEN)'((64'd1 << FW) - 64'd1);
    logic [IW-1:0]   k;
    logic [5:0]      sh;
    logic [XLEN-1:0] fmask;
    logic [XLEN-1:0] lo_src;
    assign k      = fld_idx[IW-1:0];
    assign sh     = 6'(k) * 6'(FW);
    assign fmask  = LOMASK << sh;
    assign lo_src = src_val & LOMASK;
    assign get_r[g] = (src_val >> sh) & LOMASK;
    assign set_r[g] = (dst_val & ~fmask) | (lo_src << sh);
    assign rol_r[g] = (dst_val << FW) | lo_src;
  end

  always_comb begin
    bad_op  = 1'b0;
    res_val = dst_val;
    case (op_sel)
      4'd0: res_val = get_r[0];
      4'd1: res_val = get_r[1];
      4'd2: res_val = get_r[2];
      4'd3: res_val = set_r[0];
      4'd4: res_val = set_r[1];
      4'd5: res_val = set_r[2];
      4'd6: res_val = rol_r[0];
      4'd7: res_val = rol_r[1];
      4'd8: res_val = rol_r[2];
      default: bad_op = 1'b1;
    endcase
  end
endmodule

// File: rtl/subword_unit_chk.sv
module subword_unit_chk (
  input logic [3:0]  op_sel,
  input logic [2:0]  fld_idx,
  input logic [31:0] dst_val,
  input logic [31:0] src_val,
  input logic [31:0] res_val,
  input logic        bad_op
);
  int unsigned w;
  int unsigned k;
  logic [31:0] lm;
  logic [31:0] fm;

  always_comb begin
    w  = 4 << (op_sel % 3);
    k  = (op_sel % 3 == 0) ? fld_idx : (op_sel % 3 == 1) ? fld_idx & 3 : fld_idx & 1;
    lm = (w == 16) ? 32'h0000ffff : (w == 8) ? 32'h000000ff : 32'h0000000f;
    fm = lm << (k * w);
    if (op_sel <= 4'd2) begin
      AST_GET_FIELD: assert (res_val[15:0] == (16'((src_val >> (k * w))) & lm[15:0])); // R1
      AST_GET_UPPER_ZERO: assert ((res_val & ~lm) == 32'd0); // R3
    end
    if (op_sel >= 4'd3 && op_sel <= 4'd5) begin
      AST_SET_KEEPS_REST: assert (((res_val ^ dst_val) & ~fm) == 32'd0); // R4
      AST_SET_FIELD: assert (((res_val >> (k * w)) & lm) == (src_val & lm)); // R4
    end
    if (op_sel >= 4'd6 && op_sel <= 4'd8) begin
      AST_ROL_LOW: assert ((res_val & lm) == (src_val & lm)); // R5
      AST_ROL_SHIFT: assert ((res_val >> w) == ((dst_val << w) >> w)); // R5
    end
    AST_BAD_FLAG: assert (bad_op == (op_sel > 4'd8)); // R7
    if (op_sel > 4'd8) begin
      AST_BAD_PASS: assert (res_val == dst_val); // R7
    end
  end
endmodule

bind subword_unit subword_unit_chk u_chk (
  .op_sel(op_sel), .fld_idx(fld_idx), .dst_val(dst_val),
  .src_val(src_val), .res_val(res_val), .bad_op(bad_op)
);

// File: tb/subword_unit_test.sv
module subword_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  op_sel;
  logic [2:0]  fld_idx;
  logic [31:0] dst_val, src_val, res_val;
  logic        bad_op;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  subword_unit uut (.*);

  function automatic logic [31:0] model(input int op, input int ix, input logic [31:0] d, input logic [31:0] s);
    int w, k, sh;
    logic [31:0] lm;
    if (op > 8) return d;
    w  = (op % 3 == 0) ? 4 : (op % 3 == 1) ? 8 : 16;
    k  = ix % (32 / w);
    sh = k * w;
    lm = (32'd1 << w) - 32'd1;
    if (op < 3) return (s >> sh) & lm;
    if (op < 6) return (d & ~(lm << sh)) | ((s & lm) << sh);
    return (d << w) | (s & lm);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d idx=%0d actual=%h expected=%h", req, op_sel, fld_idx, act, exp);
    end
  endtask

  function automatic string req_of(input int op, input int ix);
    if (op > 8) return "R7";
    if (op < 3) return (op == 0) ? "R1" : (ix > 3 ? "R6" : "R2");
    if (ix >= 4 && op % 3 != 0) return "R6";
    if (op < 6) return "R4";
    return "R5";
  endfunction

  logic [31:0] pats [6];

  initial begin
    pats[0] = 32'hffffffff; pats[1] = 32'h00000000; pats[2] = 32'haaaaaaaa;
    pats[3] = 32'h55555555; pats[4] = 32'h12345678; pats[5] = 32'hfedcba98;
    op_sel = 4'd0; fld_idx = 3'd0; dst_val = 32'h0; src_val = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", res_val, 32'h0);
    check("R7", {31'd0, bad_op}, 32'd0);
    for (int op = 0; op < 16; op++) begin
      for (int ix = 0; ix < 8; ix++) begin
        for (int p = 0; p < 6; p++) begin
          for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            op_sel  = 4'(op);
            fld_idx = 3'(ix);
            dst_val = (r == 0) ? pats[p] : $urandom;
            src_val = (r == 0) ? pats[5 - p] : $urandom;
            #1;
            check(req_of(op, ix), res_val, model(op, ix, dst_val, src_val));
            if (op < 3) check("R3", res_val & ~((32'd1 << (4 << (op % 3))) - 32'd1), 32'd0);
            check("R7", {31'd0, bad_op}, {31'd0, op > 8});
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule